// File: doc/BRIEF.md
# Coprocessor Response Primitive Register

This block holds the 16-bit response word that a coprocessor offers to the main processor during a multiple-register move dialog. It builds two request primitives. The first asks the main processor to read one of its integer data registers, which holds a dynamic register list. The second asks for a block transfer of coprocessor registers to or from memory. The instruction sequencer hands the block a primitive through a valid/ready issue port. The main processor polls the response word with a read strobe and reports completion with a service-done strobe.

Each primitive is offered exactly once. The first read while a primitive is on offer consumes it. From the next cycle the word shows the null primitive until service-done arrives, so one request can never be serviced twice.

A primitive issued while a request is still in progress goes into a one-entry hold slot. It becomes visible in the cycle after service-done. While the slot is full, `issue_ready` is low. A source that sees ready low must keep `issue_valid` and its fields stable, because nothing is taken in that cycle. An issue is accepted in a cycle where `issue_valid` and `issue_ready` are both high.

Top module: `crp_response_reg`

## Requirements
- R1: After reset, `resp_word` reads the null primitive 16'h0802 (bit 15 clear) and `issue_ready` is high.
- R2: A register-list request for data register n (n = 0..7) reads 16'h8C00 + n. Bit 15 is set, bits 14 and 13 are clear, bits 12:8 hold 5'h0C, bit 3 is clear (data register, not address register) and bits 2:0 hold n.
- R3: A transfer-multiple request reads 16'h810C with bit 13 equal to the direction. Direction 0 means memory to coprocessor and 1 means coprocessor to memory. Bit 15 is set, bit 14 is clear, bits 12:8 hold 5'h01 and bits 7:0 hold the 12-byte length.
- R4: An issue accepted while the block is idle is visible on `resp_word` from the next cycle. A read in the same cycle as an issue observes the previous word.
- R5: A read while a primitive is on offer makes `resp_word` read the null primitive from the next cycle on. Reads while idle or after consumption change nothing.
- R6: Service-done during an offer or after consumption returns the word to null on the next cycle, and service-done wins over a read in the same cycle. Service-done while idle has no effect.
- R7: An issue accepted while a request is in progress is held, and `issue_ready` drops while the hold slot is full. The held primitive appears in the cycle after service-done. If the slot is empty, an issue in the same cycle as service-done is presented directly on the next cycle.
- R8: While `issue_ready` is low, `issue_valid` is not accepted. After service-done, the earlier held primitive is presented, not the refused one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Primitive issue request |
| issue_ready | output | 1 | Issue can be accepted (hold slot empty) |
| issue_kind | input | 1 | 0: register-list request, 1: transfer-multiple request |
| issue_dir | input | 1 | Transfer direction, 0: memory to coprocessor, 1: coprocessor to memory |
| issue_dreg | input | 3 | Data register number holding the register list |
| resp_rd | input | 1 | Main processor read of the response word |
| svc_done | input | 1 | Main processor finished servicing the request |
| resp_word | output | 16 | Current response word |

## Verification
The bench builds the block with its default parameters: a 16-bit word, a three-bit register number and a 12-byte length. This keeps the whole primitive space small. The bench sweeps all eight register numbers and both transfer directions, and computes each expected word arithmetically from the field positions. For every dialog state it applies each strobe, including coincident pairs: read with issue, read with service-done, and issue with service-done. It also covers the full-hold-slot case, where an issue is refused and the held primitive must come out intact.

// File: rtl/crp_pkg.sv
package crp_pkg;

  typedef enum logic {
    KIND_REGSEL = 1'b0,
    KIND_XFER   = 1'b1
  } prim_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_OFFERED  = 2'd1,
    ST_CONSUMED = 2'd2
  } dlg_state_e;

endpackage

// File: rtl/crp_encoder.sv
module crp_encoder #(
  parameter int WORD_W    = 16,
  parameter int FC_W      = 5,
  parameter int PARAM_W   = 8,
  parameter int REG_W     = 3,
  parameter int XFER_LEN  = 12,
  parameter logic [FC_W-1:0] FC_REGSEL = 5'h0C,
  parameter logic [FC_W-1:0] FC_XFER   = 5'h01
) (
  input  logic              kind,
  input  logic              dir,
  input  logic [REG_W-1:0]  dreg,
  output logic [WORD_W-1:0] word
);
  import crp_pkg::*;

  localparam int CA_BIT = WORD_W - 1;
  localparam int PC_BIT = WORD_W - 2;
  localparam int DR_BIT = WORD_W - 3;
  localparam int FC_LO  = PARAM_W;
  localparam int AD_BIT = REG_W;

  logic             ca, pc, dr;
  logic [FC_W-1:0]  fc;
  logic [PARAM_W-1:0] param;

  always_comb begin
    ca    = 1'b1;
    pc    = 1'b0;
    dr    = 1'b0;
    fc    = FC_REGSEL;
    param = '0;
    if (prim_kind_e'(kind) == KIND_XFER) begin
      dr    = dir;
      fc    = FC_XFER;
      param = PARAM_W'(XFER_LEN);
    end else begin
      // data/address select stays 0: the list lives in a data register
      param[REG_W-1:0] = dreg;
      param[AD_BIT]    = 1'b0;
    end
  end

  always_comb begin
    word = '0;
    word[CA_BIT] = ca;
    word[PC_BIT] = pc;
    word[DR_BIT] = dr;
    word[FC_LO +: FC_W] = fc;
    word[PARAM_W-1:0]   = param;
  end

endmodule

// File: rtl/crp_hold_slot.sv
module crp_hold_slot #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic              valid,
  output logic [WORD_W-1:0] word
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
    end else if (push) begin
      valid <= 1'b1;
      word  <= push_word;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid);

  p_hold_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pop) |=> (valid && $stable(word)));

endmodule

// File: rtl/crp_dialog.sv
module crp_dialog #(
  parameter int WORD_W = 16,
  parameter logic [WORD_W-1:0] NULL_WORD = 16'h0802
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rd,
  input  logic              done,
  output logic              busy,
  output logic [WORD_W-1:0] resp_word
);
  import crp_pkg::*;

  dlg_state_e state, state_nx;
  logic [WORD_W-1:0] resp_nx;

  always_comb begin
    state_nx = state;
    resp_nx  = resp_word;
    if (load) begin
      state_nx = ST_OFFERED;
      resp_nx  = load_word;
    end else if (done && state != ST_IDLE) begin
      state_nx = ST_IDLE;
      resp_nx  = NULL_WORD;
    end else if (rd && state == ST_OFFERED) begin
      state_nx = ST_CONSUMED;
      resp_nx  = NULL_WORD;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      resp_word <= NULL_WORD;
    end else begin
      state     <= state_nx;
      resp_word <= resp_nx;
    end
  end

  assign busy = (state != ST_IDLE);

  p_read_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFFERED && rd && !load) |=> (resp_word == NULL_WORD));

  p_consumed_stays_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONSUMED && !load) |=> (resp_word == NULL_WORD));

  p_idle_done_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !load) |=> $stable(resp_word));

  p_offer_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (resp_word[WORD_W-1] && resp_word == $past(load_word)));

endmodule

// File: rtl/crp_response_reg.sv
module crp_response_reg #(
  parameter int WORD_W   = 16,
  parameter int FC_W     = 5,
  parameter int PARAM_W  = 8,
  parameter int REG_W    = 3,
  parameter int XFER_LEN = 12,
  parameter logic [FC_W-1:0]   FC_REGSEL = 5'h0C,
  parameter logic [FC_W-1:0]   FC_XFER   = 5'h01,
  parameter logic [WORD_W-1:0] NULL_WORD = 16'h0802
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic              issue_kind,
  input  logic              issue_dir,
  input  logic [REG_W-1:0]  issue_dreg,
  input  logic              resp_rd,
  input  logic              svc_done,
  output logic [WORD_W-1:0] resp_word
);

  localparam int FC_LO = PARAM_W;

  logic [WORD_W-1:0] enc_word, hold_word, load_word;
  logic hold_valid, busy, accept, load_new, push_hold, pop_hold, load;

  crp_encoder #(
    .WORD_W(WORD_W), .FC_W(FC_W), .PARAM_W(PARAM_W), .REG_W(REG_W),
    .XFER_LEN(XFER_LEN), .FC_REGSEL(FC_REGSEL), .FC_XFER(FC_XFER)
  ) u_enc (
    .kind(issue_kind),
    .dir (issue_dir),
    .dreg(issue_dreg),
    .word(enc_word)
  );

  assign issue_ready = !hold_valid;
  assign accept      = issue_valid && issue_ready;
  assign load_new    = accept && (!busy || svc_done);
  assign push_hold   = accept && busy && !svc_done;
  assign pop_hold    = hold_valid && busy && svc_done;
  assign load        = load_new || pop_hold;
  assign load_word   = pop_hold ? hold_word : enc_word;

  crp_hold_slot #(.WORD_W(WORD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_hold),
    .push_word(enc_word),
    .pop      (pop_hold),
    .valid    (hold_valid),
    .word     (hold_word)
  );

  crp_dialog #(.WORD_W(WORD_W), .NULL_WORD(NULL_WORD)) u_dlg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_word(load_word),
    .rd       (resp_rd),
    .done     (svc_done),
    .busy     (busy),
    .resp_word(resp_word)
  );

  p_regsel_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_word[WORD_W-1] && resp_word[FC_LO +: FC_W] == FC_REGSEL)
      |-> (resp_word[WORD_W-2:WORD_W-3] == 2'b00 && resp_word[PARAM_W-1:REG_W] == '0));

  p_xfer_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_word[WORD_W-1] && resp_word[FC_LO +: FC_W] == FC_XFER)
      |-> (!resp_word[WORD_W-2] && resp_word[PARAM_W-1:0] == PARAM_W'(XFER_LEN)));

  p_held_presented_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_hold |=> (resp_word == $past(hold_word)));

  p_refused_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready && !svc_done) |=> $stable(hold_word));

endmodule

// File: tb/crp_response_reg_test.sv
`timescale 1ns/1ps
module crp_response_reg_test;

  localparam logic [15:0] NULLW = 16'h0802;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0, issue_kind = 1'b0, issue_dir = 1'b0;
  logic [2:0] issue_dreg = '0;
  logic resp_rd = 1'b0, svc_done = 1'b0;
  logic issue_ready;
  logic [15:0] resp_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  crp_response_reg uut (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_kind(issue_kind), .issue_dir(issue_dir), .issue_dreg(issue_dreg),
    .resp_rd(resp_rd), .svc_done(svc_done), .resp_word(resp_word)
  );

  function automatic logic [15:0] exp_regsel(input int n);
    return 16'(32768 + 12 * 256 + n);
  endfunction

  function automatic logic [15:0] exp_xfer(input int d);
    return 16'(32768 + d * 8192 + 1 * 256 + 12);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // apply inputs for one cycle, return at the next falling edge
  task automatic tick(input logic v, input logic k, input logic d, input logic [2:0] r,
                      input logic rd, input logic dn);
    issue_valid = v; issue_kind = k; issue_dir = d; issue_dreg = r;
    resp_rd = rd; svc_done = dn;
    @(negedge clk);
    issue_valid = 0; resp_rd = 0; svc_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 null at reset", resp_word, NULLW);
    chk("R1 ready at reset", {15'd0, issue_ready}, 16'd1);

    for (int n = 0; n < 8; n++) begin
      // issue with a read in the same cycle: read sees the old (null) word
      chk("R4 read sees old word", resp_word, NULLW);
      tick(1, 0, 0, 3'(n), 1, 0);
      chk("R2 regsel word", resp_word, exp_regsel(n));
      tick(0, 0, 0, 0, 1, 0);
      chk("R5 null after read", resp_word, NULLW);
      tick(0, 0, 0, 0, 1, 0);
      chk("R5 second read no effect", resp_word, NULLW);
      tick(0, 0, 0, 0, 0, 1);
      chk("R6 done to null", resp_word, NULLW);
    end

    for (int d = 0; d < 2; d++) begin
      tick(1, 1, 1'(d), 3'd7, 0, 0);
      chk("R3 xfer word", resp_word, exp_xfer(d));
      tick(0, 0, 0, 0, 0, 1);
      chk("R6 done during offer", resp_word, NULLW);
    end

    // done while idle, read while idle
    tick(0, 0, 0, 0, 0, 1);
    chk("R6 idle done ignored", resp_word, NULLW);
    tick(0, 0, 0, 0, 1, 0);
    chk("R5 idle read ignored", resp_word, NULLW);
    tick(1, 0, 0, 3'd6, 0, 0);
    chk("R6 issue after idle done", resp_word, exp_regsel(6));
    // read and done together: done wins
    tick(0, 0, 0, 0, 1, 1);
    chk("R6 done beats read", resp_word, NULLW);

    // held primitive while busy
    tick(1, 0, 0, 3'd5, 0, 0);
    tick(1, 1, 1, 3'd0, 0, 0);
    chk("R7 offer unchanged while held", resp_word, exp_regsel(5));
    chk("R7 ready low when held", {15'd0, issue_ready}, 16'd0);
    tick(1, 0, 0, 3'd2, 0, 0);
    chk("R8 refused issue no change", resp_word, exp_regsel(5));
    tick(0, 0, 0, 0, 1, 0);
    chk("R5 consumed", resp_word, NULLW);
    tick(0, 0, 0, 0, 0, 1);
    chk("R8 held one presented", resp_word, exp_xfer(1));
    chk("R7 ready back", {15'd0, issue_ready}, 16'd1);
    tick(0, 0, 0, 0, 0, 1);
    chk("R6 done clears", resp_word, NULLW);

    // issue together with done, slot empty
    tick(1, 0, 0, 3'd3, 0, 0);
    tick(1, 1, 0, 3'd0, 0, 1);
    chk("R7 direct load on done", resp_word, exp_xfer(0));
    tick(0, 0, 0, 0, 0, 1);
    chk("R6 clear", resp_word, NULLW);

    // issue and read in the same cycle while offered
    tick(1, 0, 0, 3'd1, 0, 0);
    chk("R4 read sees offered", resp_word, exp_regsel(1));
    tick(1, 1, 1, 3'd0, 1, 0);
    chk("R5 read consumed old", resp_word, NULLW);
    tick(0, 0, 0, 0, 0, 1);
    chk("R7 held after consumed", resp_word, exp_xfer(1));
    tick(0, 0, 0, 0, 0, 1);
    chk("R6 final idle", resp_word, NULLW);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule